// File: doc/BRIEF.md
# Priority-Interleaved ADC Sweep Sequencer

This block drives a multiplexed analog-to-digital converter through an endless sweep of one eight-channel input group. A few low-numbered channels are marked as priority channels and are sampled far more often than the rest. Before each ordinary channel is visited, every priority channel is converted once, in ascending order. The ordinary channels take turns in ascending cyclic order. Each 10-bit result lands in a result register that belongs to the converted channel, and software reads those registers through a combinational read port.

A sweep starts from a run bit. It begins at once in software-trigger mode. In external-trigger mode it waits for the first falling edge of an active-low trigger line that occurs while the block is armed. The sweep stops only when the run bit is cleared. A conversion that is still in flight when the run bit is cleared is dropped. The next sweep starts again from channel 0. The converter sits behind a simple handshake: a one-cycle start pulse with a channel index and a group index, then a done pulse with the result.

Top module: `adc_sweep_seq`

## Requirements
- R1: After reset, `conv_start` is 0 and every result register reads 0.
- R2: With `ext_trig_sel` = 0, the first `conv_start` pulse appears in the cycle right after the first clock edge that samples `run_en` = 1, and its channel is 0.
- R3: With `ext_trig_sel` = 1, no conversion starts until `trig_n` goes from 1 to 0 while the block is armed. A falling edge seen before `run_en` was set is ignored. The first pulse follows the clock edge that sees the low level, and its channel is 0.
- R4: Let N be the size of the priority set. Conversion k of a sweep (k counted from 0) uses channel (k mod (N+1)) when that value is below N. Otherwise it uses channel N + ((k div (N+1)) mod (8−N)). The order wraps without end.
- R5: `prio_sel` values 0, 1, 2 and 3 give a priority set of {0}, {0,1}, {0,1,2} and {0,1,2,3}. The value is captured when the sweep starts.
- R6: `conv_start` is a one-cycle pulse. After a `conv_done`, the next pulse follows one cycle later. No new pulse is issued while a conversion is outstanding.
- R7: `conv_data`, when it arrives with `conv_done`, is stored in the result register of the channel named by the matching `conv_start`. Other registers keep their values. `rd_data` shows the register selected by `rd_chan`.
- R8: Clearing `run_en` stops the sweep: no further `conv_start` is issued. A `conv_done` that arrives after the clear writes nothing. The next sweep starts again at channel 0.
- R9: `conv_group` takes the value of `group_sel` when the sweep starts and holds it until the sweep stops. A value of 3, which names no group, selects group 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Run bit: 1 starts or keeps the sweep, 0 stops it |
| ext_trig_sel | input | 1 | 0 = start at once, 1 = wait for a trigger falling edge |
| prio_sel | input | 2 | Size of the priority set minus one |
| group_sel | input | 2 | Selects one of three input groups |
| trig_n | input | 1 | External trigger, active on its falling edge |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 3 | Channel index for the conversion |
| conv_group | output | 2 | Group index for the multiplexer |
| conv_done | input | 1 | Converter reports a finished conversion |
| conv_data | input | 10 | Conversion result |
| rd_chan | input | 3 | Result register to read |
| rd_data | output | 10 | Contents of the selected result register |

## Verification
The assertions assume a converter that answers each start pulse with exactly one done pulse. That done pulse must arrive one or more cycles after the start pulse, and never in the same cycle as a start pulse. The bench's converter model keeps to this. It raises `conv_done` at least one cycle after it sees a start, and it holds the pulse for a single cycle. Its only out-of-contract stimulus is the stale done sent after an abort. That done comes in the same cycle as the run bit is cleared, so the block has already dropped the conversion.

// File: rtl/adc_sweep_pkg.sv
// Package: shared state encoding for the sweep sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package adc_sweep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } sweep_state_t;
endpackage

// File: rtl/adc_sweep_fall.sv
// Module: detects a high-to-low transition on the active-low trigger line.
// Assumes: trig_n is already synchronous to clk.
module adc_sweep_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_n,
    output logic fall
);
    logic trig_prev;

    // Keep the previous trigger level; the line idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_prev <= 1'b1;
        else        trig_prev <= trig_n;
    end

    assign fall = trig_prev && !trig_n;
endmodule

// File: rtl/adc_sweep_order.sv
// Module: produces the interleaved channel order. The priority channels
// 0..P run in ascending order, then one ordinary channel; the ordinary
// channels P+1..NUM_CH-1 rotate.
// Assumes: prio_last is held constant while restart is low.
module adc_sweep_order #(
    parameter int NUM_CH = 8,
    parameter int PRIO_W = 2,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic [PRIO_W-1:0] prio_last,
    output logic [CH_W-1:0]   cur_chan
);
    logic [CH_W-1:0] prio_ext;
    logic [CH_W-1:0] first_plain;
    logic [CH_W-1:0] next_plain;

    assign prio_ext    = CH_W'(prio_last);
    assign first_plain = prio_ext + CH_W'(1);

    // Step through the order; restart parks it at channel 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_chan   <= '0;
            next_plain <= CH_W'(1);
        end else if (restart) begin
            cur_chan   <= '0;
            next_plain <= first_plain;
        end else if (advance) begin
            if (cur_chan < prio_ext) begin
                cur_chan <= cur_chan + CH_W'(1);
            end else if (cur_chan == prio_ext) begin
                cur_chan <= next_plain;
            end else begin
                cur_chan   <= '0;
                next_plain <= (next_plain == CH_W'(NUM_CH - 1)) ? first_plain
                                                                : next_plain + CH_W'(1);
            end
        end
    end
endmodule

// File: rtl/adc_sweep_results.sv
// Module: one result register per channel, with a combinational read port.
// Assumes: at most one write per cycle.
module adc_sweep_results #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 10,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_chan,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] bank [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
        // Load this channel's register when its result arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  bank[g] <= '0;
            else if (wr_en && wr_chan == CH_W'(g))       bank[g] <= wr_data;
        end
    end

    assign rd_data = bank[rd_chan];
endmodule

// File: rtl/adc_sweep_seq.sv
// Module: top of the sweep sequencer. It runs the start/wait state machine,
// captures the group and the priority settings, and joins the order
// generator, the trigger detector and the result bank.
// Assumes: the converter answers each start with exactly one done pulse,
// and that pulse comes one or more cycles later.
module adc_sweep_seq #(
    parameter int NUM_CH     = 8,
    parameter int DATA_W     = 10,
    parameter int NUM_GROUPS = 3,
    parameter int PRIO_W     = 2,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              ext_trig_sel,
    input  logic [PRIO_W-1:0] prio_sel,
    input  logic [GRP_W-1:0]  group_sel,
    input  logic              trig_n,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    output logic [GRP_W-1:0]  conv_group,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [CH_W-1:0]   rd_chan,
    output logic [DATA_W-1:0] rd_data
);
    import adc_sweep_pkg::*;

    sweep_state_t      state;
    logic [GRP_W-1:0]  group_q;
    logic [PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0] prio_eff;
    logic [GRP_W-1:0]  group_ok;
    logic              trig_fall;
    logic              take_result;
    logic [CH_W-1:0]   cur_chan;

    // A group number beyond the last group falls back to group 0.
    assign group_ok = ({1'b0, group_sel} < (GRP_W + 1)'(NUM_GROUPS)) ? group_sel : '0;

    // Show the live field while idle so that the order restarts from the value being captured.
    assign prio_eff = (state == ST_IDLE) ? prio_sel : prio_q;

    assign take_result = (state == ST_WAIT) && conv_done && run_en;

    // Sweep control: idle, armed for a trigger, issue, wait for done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            group_q <= '0;
            prio_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (run_en) begin
                    group_q <= group_ok;
                    prio_q  <= prio_sel;
                    state   <= ext_trig_sel ? ST_ARMED : ST_ISSUE;
                end
                ST_ARMED: begin
                    if (!run_en)        state <= ST_IDLE;
                    else if (trig_fall) state <= ST_ISSUE;
                end
                ST_ISSUE: state <= run_en ? ST_WAIT : ST_IDLE;
                ST_WAIT: begin
                    if (!run_en)        state <= ST_IDLE;
                    else if (conv_done) state <= ST_ISSUE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign conv_start = (state == ST_ISSUE) && run_en;
    assign conv_chan  = cur_chan;
    assign conv_group = group_q;

    adc_sweep_fall i_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_n (trig_n),
        .fall   (trig_fall)
    );

    adc_sweep_order #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) i_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (state == ST_IDLE),
        .advance   (take_result),
        .prio_last (prio_eff),
        .cur_chan  (cur_chan)
    );

    adc_sweep_results #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_results (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take_result),
        .wr_chan (cur_chan),
        .wr_data (conv_data),
        .rd_chan (rd_chan),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/adc_sweep_seq_chk.sv
// Checker: protocol and ordering properties of the sweep sequencer.
// Assumes: the converter answers each start with one done, one or more cycles later.
module adc_sweep_seq_chk #(
    parameter int CH_W  = 3,
    parameter int GRP_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             conv_start,
    input logic [CH_W-1:0]  conv_chan,
    input logic [GRP_W-1:0] conv_group,
    input logic             conv_done
);
    logic             outstanding;
    logic             continuing;
    logic [GRP_W-1:0] last_group;
    logic [CH_W-1:0]  last_chan;

    // Follow the conversion in flight and the previous start within this sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
            continuing  <= 1'b0;
            last_group  <= '0;
            last_chan   <= '0;
        end else if (!run_en) begin
            outstanding <= 1'b0;
            continuing  <= 1'b0;
        end else begin
            if (conv_start)     outstanding <= 1'b1;
            else if (conv_done) outstanding <= 1'b0;
            if (conv_start) begin
                continuing <= 1'b1;
                last_group <= conv_group;
                last_chan  <= conv_chan;
            end
        end
    end

    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_single_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !outstanding);

    assert_start_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(run_en));

    assert_group_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && continuing) |-> (conv_group == last_group));

    assert_plain_then_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && continuing && last_chan > CH_W'(3)) |-> (conv_chan == '0));
endmodule

bind adc_sweep_seq adc_sweep_seq_chk #(.CH_W(CH_W), .GRP_W(GRP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_group (conv_group),
    .conv_done  (conv_done)
);

// File: tb/test_adc_sweep_seq.sv
`timescale 1ns/1ps
module test_adc_sweep_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       ext_trig_sel = 1'b0;
    logic [1:0] prio_sel = '0;
    logic [1:0] group_sel = '0;
    logic       trig_n = 1'b1;
    logic       conv_start;
    logic [2:0] conv_chan;
    logic [1:0] conv_group;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic [2:0] rd_chan = '0;
    logic [9:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    logic [9:0] exp_res [8];

    always #2 clk = ~clk;

    adc_sweep_seq i_adc_sweep_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ext_trig_sel(ext_trig_sel),
        .prio_sel(prio_sel), .group_sel(group_sel), .trig_n(trig_n),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_group(conv_group),
        .conv_done(conv_done), .conv_data(conv_data),
        .rd_chan(rd_chan), .rd_data(rd_data)
    );

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
            summary_and_end();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_chan(input int n, input int k);
        int j = k % (n + 1);
        if (j < n) return j;
        return n + ((k / (n + 1)) % (8 - n));
    endfunction

    task automatic wait_start(output int waited);
        waited = 0;
        while (!conv_start && waited < 64) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic reply(input int lat, input logic [9:0] val);
        repeat (lat) @(negedge clk);
        conv_done = 1'b1;
        conv_data = val;
        exp_res[conv_chan_seen] = val;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    int conv_chan_seen;

    task automatic read_all(input string req);
        for (int c = 0; c < 8; c++) begin
            rd_chan = c[2:0];
            #1;
            check(rd_data == exp_res[c], req, rd_data, exp_res[c]);
        end
    endtask

    task automatic stop_and_idle();
        run_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(conv_start == 1'b0, "R8 no start after stop", conv_start, 0);
        end
    endtask

    // One software-triggered sweep over nconv conversions with order and result checks.
    task automatic run_sweep(input int psel, input int grp, input int nconv);
        int n = psel + 1;
        int w;
        int egrp = (grp > 2) ? 0 : grp;
        prio_sel = psel[1:0];
        group_sel = grp[1:0];
        ext_trig_sel = 1'b0;
        run_en = 1'b1;
        for (int k = 0; k < nconv; k++) begin
            wait_start(w);
            if (k == 0) begin
                check(w == 1, "R2 start one cycle after run", w, 1);
                group_sel = 2'((grp + 1) % 3);
                prio_sel = 2'(psel ^ 1);
            end else begin
                check(w == 0, "R6 restart one cycle after done", w, 0);
            end
            check(conv_chan == 3'(exp_chan(n, k)), "R4 R5 channel order", conv_chan, exp_chan(n, k));
            check(conv_group == 2'(egrp), "R9 group held", conv_group, egrp);
            @(negedge clk);
            check(conv_start == 1'b0, "R6 single cycle start", conv_start, 0);
            conv_chan_seen = exp_chan(n, k);
            reply(k % 3, 10'((egrp * 97 + conv_chan_seen * 31 + k * 7 + psel * 13) & 10'h3FF));
        end
        stop_and_idle();
        read_all("R7 per-channel result");
    endtask

    initial begin
        int w;
        for (int c = 0; c < 8; c++) exp_res[c] = '0;
        repeat (3) @(negedge clk);
        check(conv_start == 1'b0, "R1 reset start low", conv_start, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(conv_start == 1'b0, "R1 idle start low", conv_start, 0);
        read_all("R1 results cleared");

        for (int p = 0; p < 4; p++)
            for (int g = 0; g < 3; g++)
                run_sweep(p, g, 2 * (8 - (p + 1)) * (p + 2));

        // R9: group value 3 selects group 0.
        run_sweep(1, 3, 6);

        // R8: abort in flight, stale done ignored, restart from channel 0.
        prio_sel = 2'd0; group_sel = 2'd1; ext_trig_sel = 1'b0; run_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            wait_start(w);
            @(negedge clk);
            conv_chan_seen = exp_chan(1, k);
            reply(1, 10'(100 + k));
        end
        wait_start(w);
        check(conv_chan == 3'd2, "R4 fourth conversion", conv_chan, 2);
        @(negedge clk);
        run_en = 1'b0;
        conv_done = 1'b1;
        conv_data = 10'h155;
        @(negedge clk);
        conv_done = 1'b0;
        rd_chan = 3'd2;
        #1;
        check(rd_data == exp_res[2], "R8 aborted result discarded", rd_data, exp_res[2]);
        read_all("R8 no register touched");
        run_en = 1'b1;
        wait_start(w);
        check(conv_chan == 3'd0, "R8 restart at channel 0", conv_chan, 0);
        @(negedge clk);
        stop_and_idle();

        // R3: external trigger; an edge before the run bit is ignored.
        ext_trig_sel = 1'b1; prio_sel = 2'd2; group_sel = 2'd2;
        trig_n = 1'b0;
        @(negedge clk);
        run_en = 1'b1;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (conv_start) seen = 1'b1;
            end
            check(seen == 1'b0, "R3 early edge ignored", seen, 0);
        end
        trig_n = 1'b1;
        @(negedge clk);
        check(conv_start == 1'b0, "R3 rising edge does not start", conv_start, 0);
        trig_n = 1'b0;
        @(negedge clk);
        check(conv_start == 1'b1, "R3 start after falling edge", conv_start, 1);
        check(conv_chan == 3'd0, "R3 first channel", conv_chan, 0);
        check(conv_group == 2'd2, "R9 group captured", conv_group, 2);
        @(negedge clk);
        stop_and_idle();

        summary_and_end();
    end
endmodule